// File: doc/BRIEF.md
# Conditional-Block Execution State Advancer

This block keeps the 8-bit execution state of a conditional instruction block ("if-then" block) for a processor core. Within the status word that state is not in one piece: six of its bits sit in status bits [15:10] and the other two sit in status bits [26:25]. The upper four state bits, status [15:12], hold the base condition that applies to the next instruction. The lower four bits form the block's remaining-length mask. That mask is made of status bits 11, 10, 26 and 25, with bit 11 the most significant.

Each time an instruction retires, the block moves the state forward by one step. The step is a one-place left shift of the mask through the scattered bit positions. When the mask runs out, the base condition is cleared. The block also offers a combinational view of the state as it stands after one more step. When an exception is taken on the trapping instruction, the saved status can be taken from this view. It then already applies to the following instruction, and the handler needs no fix-up.

On return from an exception, the restored status word is presented on the load port together with a load strobe. The block takes only the conditional-block fields from that word. All other status bits pass from the load bus straight to both status outputs.

Top module: `it_state_advancer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state is cleared, and from that edge on cond_o reads 0, in_it_o reads 0 and status bits [15:10] and [26:25] of status_o read 0.
- R2: When load_valid is high at a rising edge, from that edge on status_o bits [15:10] and [26:25] equal the same bits of load_word as sampled at that edge.
- R3: When retire is high, load_valid is low and the mask {bit11,bit10,bit26,bit25} is neither 0000 nor 1000, the next state writes {mask,0} into status bits {12,11,10,26,25} and leaves bits [15:13] unchanged.
- R4: When retire is high, load_valid is low and the mask is 1000, the shifted mask's low four bits are zero, so all eight state bits become 0 and in_it_o falls.
- R5: When retire is high, load_valid is low and the mask is 0000, no shift takes place and status bits [15:12] are cleared.
- R6: When load_valid and retire are both high at the same edge, the load takes effect and the state is not advanced.
- R7: With load_valid and retire both low, the state holds.
- R8: cond_o equals the stored status bits [15:12], and in_it_o is high exactly when the stored mask is nonzero.
- R9: save_o shows, in the same cycle, the state after one step as defined by R3 to R5, placed into the load_word bits. After a retire edge, status_o shows exactly what save_o showed before that edge.
- R10: All bits of status_o and save_o outside [15:10] and [26:25] follow load_word combinationally. The conditional-block bits of load_word have no effect while load_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Take the conditional-block fields of load_word |
| load_word | input | STATUS_W | Status word bus: restored word on load, source of pass-through bits |
| retire | input | 1 | One instruction retired; advance the state |
| status_o | output | STATUS_W | load_word with the current conditional-block fields inserted |
| save_o | output | STATUS_W | load_word with the once-advanced conditional-block fields inserted |
| cond_o | output | 4 | Base condition for the next instruction |
| in_it_o | output | 1 | A conditional block is active |

## Verification
status_o, cond_o and in_it_o change on the first rising edge after a load, retire or reset. The bench therefore drives its inputs on a falling edge and samples these results on the next falling edge, one rising edge later. save_o and the pass-through bits are combinational: the bench checks them on the same falling edge on which it drives their inputs, after a short settling delay and before any rising edge. For back-to-back retires, every intermediate state is sampled between edges, so each single step is checked on its own.

// File: rtl/it_adv_pkg.sv
// Package: shared types and the mapping of the conditional-block state
// onto its scattered status-word positions.
// Assumes: state bit order {cond[3:0], mask[3:0]}, mask MSB at status bit 11.
package it_adv_pkg;

    localparam int IT_BITS      = 8;
    localparam int COND_W       = 4;
    localparam int MASK_W       = 4;
    localparam int MIN_STATUS_W = 27;

    typedef struct packed {
        logic [COND_W-1:0] cond;   // status [15:12]
        logic [MASK_W-1:0] mask;   // status {11,10,26,25}
    } it_state_t;

    // Status-word position of flat state bit idx (0 = LSB of the mask).
    function automatic int it_pos(input int idx);
        int p;
        case (idx)
            0:       p = 25;
            1:       p = 26;
            default: p = idx + 8;   // 2..7 -> 10..15
        endcase
        return p;
    endfunction

endpackage

// File: rtl/it_field_extract.sv
// Module: gathers the eight scattered conditional-block bits out of a
// status word into the packed state type.
// Assumes: STATUS_W >= MIN_STATUS_W; bits outside the fields are ignored here.
module it_field_extract
    import it_adv_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic [STATUS_W-1:0] word_i,
    output it_state_t           state_o
);

    logic [IT_BITS-1:0] flat;

    // One wire per state bit, picked from its status position.
    for (genvar i = 0; i < IT_BITS; i++) begin : g_pick
        localparam int P = it_pos(i);
        assign flat[i] = word_i[P];
    end

    assign state_o = it_state_t'(flat);

endmodule

// File: rtl/it_field_insert.sv
// Module: writes the packed state back into its scattered status positions
// over a base word; every other bit of the base passes through unchanged.
// Assumes: STATUS_W >= MIN_STATUS_W.
module it_field_insert
    import it_adv_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic [STATUS_W-1:0] base_i,
    input  it_state_t           state_i,
    output logic [STATUS_W-1:0] word_o
);

    logic [IT_BITS-1:0] flat;
    assign flat = state_i;

    // Overlay the state bits on the pass-through word.
    always_comb begin
        word_o = base_i;
        for (int i = 0; i < IT_BITS; i++) begin
            word_o[it_pos(i)] = flat[i];
        end
    end

endmodule

// File: rtl/it_step.sv
// Module: one advance step of the conditional-block state (pure logic).
// A nonzero mask shifts left one place, its top bit landing in cond[0];
// whenever the resulting mask is zero, the condition nibble is cleared.
// Assumes: called once per retired instruction by the state register.
module it_step
    import it_adv_pkg::*;
(
    input  it_state_t cur_i,
    output it_state_t nxt_o
);

    logic [MASK_W:0] shifted;

    // Five-bit shift of the mask, only when the mask is nonzero.
    always_comb begin
        shifted = {cur_i.mask, 1'b0};
        nxt_o   = cur_i;
        if (cur_i.mask != '0) begin
            nxt_o.mask = shifted[MASK_W-1:0];
            nxt_o.cond = {cur_i.cond[COND_W-1:1], shifted[MASK_W]};
        end
        if (nxt_o.mask == '0) begin
            nxt_o.cond = '0;
        end
    end

endmodule

// File: rtl/it_state_reg.sv
// Module: the stored conditional-block state with load-over-advance priority.
// Assumes: synchronous active-low reset; load and retire share clk.
module it_state_reg
    import it_adv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_valid,
    input  it_state_t load_state_i,
    input  logic      retire,
    input  it_state_t step_state_i,
    output it_state_t state_o
);

    // Reset clears, load wins over retire, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= '0;
        end else if (load_valid) begin
            state_o <= load_state_i;
        end else if (retire) begin
            state_o <= step_state_i;
        end
    end

endmodule

// File: rtl/it_state_advancer.sv
// Module (top): keeps the conditional-block execution state, advances it on
// each retire, and presents current and once-advanced status views.
// Assumes: load_word carries the pass-through status bits at all times;
// its conditional-block bits matter only while load_valid is high.
module it_state_advancer
    import it_adv_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_valid,
    input  logic [STATUS_W-1:0] load_word,
    input  logic                retire,
    output logic [STATUS_W-1:0] status_o,
    output logic [STATUS_W-1:0] save_o,
    output logic [COND_W-1:0]   cond_o,
    output logic                in_it_o
);

    it_state_t ld_state;
    it_state_t cur_state;
    it_state_t nxt_state;

    it_field_extract #(.STATUS_W(STATUS_W)) u_extract (
        .word_i  (load_word),
        .state_o (ld_state)
    );

    it_step u_step (
        .cur_i (cur_state),
        .nxt_o (nxt_state)
    );

    it_state_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_valid   (load_valid),
        .load_state_i (ld_state),
        .retire       (retire),
        .step_state_i (nxt_state),
        .state_o      (cur_state)
    );

    it_field_insert #(.STATUS_W(STATUS_W)) u_insert_cur (
        .base_i  (load_word),
        .state_i (cur_state),
        .word_o  (status_o)
    );

    it_field_insert #(.STATUS_W(STATUS_W)) u_insert_nxt (
        .base_i  (load_word),
        .state_i (nxt_state),
        .word_o  (save_o)
    );

    assign cond_o  = cur_state.cond;
    assign in_it_o = |cur_state.mask;

endmodule

// File: rtl/it_state_advancer_chk.sv
// Module: assertion checker for it_state_advancer, attached by bind.
// Assumes: field positions [15:10] and [26:25]; reads top-level ports only.
module it_state_advancer_chk #(
    parameter int STATUS_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load_valid,
    input logic [STATUS_W-1:0] load_word,
    input logic                retire,
    input logic [STATUS_W-1:0] status_o,
    input logic [STATUS_W-1:0] save_o,
    input logic [3:0]          cond_o,
    input logic                in_it_o
);

    function automatic logic [7:0] fld(input logic [STATUS_W-1:0] w);
        return {w[15:10], w[26:25]};
    endfunction

    logic [7:0] cur;
    assign cur = fld(status_o);

    logic rst_seen_q;
    // Remember whether the last rising edge saw reset asserted.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: state reads zero after a reset edge.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_clear: assert (cur == 8'h00 && cond_o == 4'h0 && !in_it_o)
                else $error("a_r1_reset_clear");
        end
    end

    // R2 and R6: a load lands even when retire is also high.
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> fld(status_o) == $past(fld(load_word)));

    a_r3_mask_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !load_valid && cur[3:0] != 4'h0 && cur[3:0] != 4'h8)
        |=> fld(status_o) == {$past(cur[7:5]), $past(cur[3:0]), 1'b0});

    a_r4_block_end: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !load_valid && cur[3:0] == 4'h8)
        |=> (fld(status_o) == 8'h00 && !in_it_o));

    a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !load_valid && cur[3:0] == 4'h0) |=> fld(status_o) == 8'h00);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !load_valid) |=> $stable(fld(status_o)));

    a_r8_in_it: assert property (@(posedge clk) disable iff (!rst_n)
        (in_it_o == (cur[3:0] != 4'h0)) && (cond_o == cur[7:4]));

    a_r9_save_next: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !load_valid) |=> fld(status_o) == $past(fld(save_o)));

endmodule

bind it_state_advancer it_state_advancer_chk #(.STATUS_W(STATUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_word  (load_word),
    .retire     (retire),
    .status_o   (status_o),
    .save_o     (save_o),
    .cond_o     (cond_o),
    .in_it_o    (in_it_o)
);

// File: tb/it_state_advancer_test.sv
module it_state_advancer_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam logic [W-1:0] NONIT = 32'hF9FF_03FF;
    localparam int NVEC = 10;
    // {state loaded, state after one retire}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        16'h0000, 16'hF000, 16'h0800, 16'h1408, 16'hA2A4,
        16'h6F7E, 16'h3932, 16'hC800, 16'h5B56, 16'h0102
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load_valid;
    logic [W-1:0] load_word;
    logic         retire;
    logic [W-1:0] status_o;
    logic [W-1:0] save_o;
    logic [3:0]   cond_o;
    logic         in_it_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    it_state_advancer #(.STATUS_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
        .retire(retire), .status_o(status_o), .save_o(save_o),
        .cond_o(cond_o), .in_it_o(in_it_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] put(input logic [W-1:0] b, input logic [7:0] s);
        logic [W-1:0] w = b;
        w[15:10] = s[7:2];
        w[26:25] = s[1:0];
        return w;
    endfunction

    function automatic logic [7:0] get(input logic [W-1:0] w);
        return {w[15:10], w[26:25]};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_load(input logic [7:0] s, input logic [W-1:0] b);
        @(negedge clk);
        load_valid = 1'b1;
        load_word  = put(b, s);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_retire();
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; load_valid = 1'b0; retire = 1'b0;
        load_word = 32'hA5A5_A5A5;
        repeat (3) @(negedge clk);
        chk("R1 reset fields", get(status_o), 8'h00);
        chk("R1 reset cond", cond_o, 4'h0);
        chk("R1 reset in_it", in_it_o, 1'b0);
        chk("R10 pass-through in reset", status_o & NONIT, load_word & NONIT);
        rst_n = 1'b1;

        // Table walk: load, check current and next views, retire, check.
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] s_in  = VEC[i][15:8];
            logic [7:0] s_exp = VEC[i][7:0];
            logic [W-1:0] b   = 32'h1234_5678 ^ (i * 32'h0101_0101);
            string tag;
            if (s_in[3:0] == 4'h0)      tag = "R5";
            else if (s_in[3:0] == 4'h8) tag = "R4";
            else                        tag = "R3";
            do_load(s_in, b);
            // Garbage fields on the bus while load_valid is low (R10).
            load_word = put(~b, ~s_in);
            #1;
            chk("R2 loaded fields", get(status_o), s_in);
            chk("R8 cond", cond_o, s_in[7:4]);
            chk("R8 in_it", in_it_o, |s_in[3:0]);
            chk("R9 save view", get(save_o), s_exp);
            chk("R10 pass-through", status_o & NONIT, ~b & NONIT);
            do_retire();
            chk({tag, " after retire"}, get(status_o), s_exp);
        end

        // R7: idle cycles hold the state.
        do_load(8'h39, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 hold", get(status_o), 8'h39);

        // R6: simultaneous load and retire, load wins.
        load_valid = 1'b1; retire = 1'b1; load_word = put(32'h0, 8'hA2);
        @(negedge clk);
        load_valid = 1'b0; retire = 1'b0;
        chk("R6 load priority", get(status_o), 8'hA2);

        // Chain of four back-to-back retires through the end of a block.
        do_load(8'h6F, 32'hFFFF_FFFF);
        retire = 1'b1;
        @(negedge clk); chk("R3 chain step1", get(status_o), 8'h7E);
        @(negedge clk); chk("R3 chain step2", get(status_o), 8'h7C);
        @(negedge clk); chk("R3 chain step3", get(status_o), 8'h78);
        chk("R8 in_it mid chain", in_it_o, 1'b1);
        @(negedge clk); chk("R4 chain end", get(status_o), 8'h00);
        chk("R4 in_it falls", in_it_o, 1'b0);
        retire = 1'b0;

        // R1: reset in the middle of a block.
        do_load(8'h5B, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-block reset", get(status_o), 8'h00);
        chk("R1 mid-block cond", cond_o, 4'h0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule